// File: doc/BRIEF.md
# PCI Bus Cycle Classifier

This block watches the control lines of a conventional PCI bus, already sampled into flip-flops by the surrounding capture logic, and labels every clock with a set of active-low cycle-status bits. The bits say whether the bus is idle, whether data moved, which side inserted a wait state, and whether the transaction ended through a retry, a target abort, a master abort or a normal completion. A trigger or bus-utilisation unit downstream uses the bits to pick, count and store bus cycles.

The block never drives the bus. It keeps a small amount of per-transaction state: whether data has moved, whether the target has claimed the transaction, whether the transfer is a burst, and a clock counter for the master-abort timeout. It also gives a copy of the grant line that is frozen for the length of a transaction, and a store-qualify output that drops wait or idle cycles when two filter inputs ask for it.

All status outputs are combinational functions of the sampled bus lines of the current clock and of state registered on earlier clocks. All bus inputs are active low; the two filter inputs are active high.

Top module: `pci_cycle_classifier`

## Requirements
- R1: `idle_n` is low in exactly the clocks where FRAME# and IRDY# are both deasserted.
- R2: Inside a transaction (any clock after the address phase until the transaction ends), `dvalid_n` is low when IRDY# and TRDY# are both asserted.
- R3: Inside a transaction, three wait bits are decoded: `mwait_n` low when FRAME# is asserted and IRDY# is not; `twait_n` low when IRDY# and DEVSEL# are asserted and TRDY# and STOP# are not; `nodev_n` low when IRDY# is asserted, TRDY# and DEVSEL# are deasserted, and DEVSEL# has not been asserted earlier in the transaction.
- R4: `retry_n` is low in a transaction clock where STOP# and DEVSEL# are asserted, TRDY# is deasserted and no data phase has completed yet in that transaction.
- R5: `tabort_n` is low for one clock only: the first clock of a transaction in which STOP# is asserted and DEVSEL# is deasserted after DEVSEL# was asserted earlier in that transaction.
- R6: For a single transfer (FRAME# deasserted on the first clock that IRDY# is asserted, or IRDY# not yet asserted), `mabort_n` is low for one clock, five clocks after the address phase, if DEVSEL# has never been asserted.
- R7: For a burst (FRAME# still asserted on the first clock that IRDY# is asserted), the master-abort pulse comes six clocks after the address phase instead.
- R8: `eot_n` is low for exactly one clock, the last clock of a transaction: FRAME# deasserted, IRDY# asserted, and TRDY# or STOP# asserted or a master abort signalled in this or an earlier clock of the transaction.
- R9: `gnt_held_n` follows GNT# outside transactions and in the address-phase clock; through the rest of the transaction it holds the GNT# value sampled in the address phase.
- R10: When `no_wait` is high, `store_q` is low in every clock where any of the three wait bits is low.
- R11: When `no_idle` is high, `store_q` is low in every idle clock; with both filters low, `store_q` is always high.
- R12: After a synchronous reset with an idle bus, only `idle_n` is low, `store_q` is high and no transaction is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| trdy_n | input | 1 | Sampled TRDY#, active low |
| devsel_n | input | 1 | Sampled DEVSEL#, active low |
| stop_n | input | 1 | Sampled STOP#, active low |
| gnt_n | input | 1 | Sampled GNT# of the observed slot, active low |
| no_wait | input | 1 | Filter: drop wait clocks from storage |
| no_idle | input | 1 | Filter: drop idle clocks from storage |
| idle_n | output | 1 | Bus idle |
| dvalid_n | output | 1 | Data transferred this clock |
| mwait_n | output | 1 | Wait inserted by the initiator |
| twait_n | output | 1 | Wait inserted by the target |
| nodev_n | output | 1 | Wait because no target has claimed yet |
| retry_n | output | 1 | Retry termination |
| tabort_n | output | 1 | Target abort, one clock |
| mabort_n | output | 1 | Master abort, one clock |
| eot_n | output | 1 | Last clock of the transaction |
| gnt_held_n | output | 1 | GNT# frozen for the transaction |
| store_q | output | 1 | Clock qualified for storage, active high |

## Verification
On every clock the embedded properties check that the abort and end-of-transaction bits never last two clocks, that a master abort never coincides with DEVSEL#, that an idle clock carries no data or wait bit, that the held grant copy stays put inside a transaction, and that the filters really remove wait and idle clocks from storage. Only the bench scenarios can show that the master abort lands on the fifth clock for a single transfer and the sixth for a burst, that retry is told apart from target abort by whether data has moved or the target had claimed, and that the end-of-transaction pulse lands on the right clock for normal, retried, aborted and timed-out transactions.

// File: rtl/pci_cyc_pkg.sv
// Shared types for the bus cycle classifier.
// Assumes: all fields are active high (asserted = 1) inside the block.
package pci_cyc_pkg;

    // Sampled bus control lines, converted to asserted-high.
    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic devsel;
        logic stop;
        logic gnt;
    } bus_t;

    // Per-clock cycle status, asserted-high.
    typedef struct packed {
        logic idle;
        logic dvalid;
        logic mwait;
        logic twait;
        logic nodev;
        logic retry;
        logic tabort;
        logic mabort;
        logic eot;
    } stat_t;

endpackage

// File: rtl/pci_cyc_track.sv
// Transaction tracker: opens a transaction on the address phase and keeps
// the per-transaction history the decoder needs (data moved, target claimed,
// first IRDY# seen, burst flag, one-shot abort flags, grant copy).
// Assumes: inputs are registered bus lines, asserted-high.
module pci_cyc_track
    import pci_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  bus_t bus,
    input  logic eot,
    input  logic ta_now,
    input  logic ma_now,
    output logic txn,
    output logic start,
    output logic data_seen,
    output logic devsel_seen,
    output logic irdy_seen,
    output logic burst_q,
    output logic ta_done,
    output logic ma_done,
    output logic gnt_q
);

    // Address phase: FRAME# asserted while no transaction is open.
    assign start = !txn && bus.frame;

    // Per-transaction history registers, cleared on each new address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn         <= 1'b0;
            data_seen   <= 1'b0;
            devsel_seen <= 1'b0;
            irdy_seen   <= 1'b0;
            burst_q     <= 1'b0;
            ta_done     <= 1'b0;
            ma_done     <= 1'b0;
            gnt_q       <= 1'b0;
        end else if (start) begin
            txn         <= 1'b1;
            data_seen   <= 1'b0;
            devsel_seen <= 1'b0;
            irdy_seen   <= 1'b0;
            burst_q     <= 1'b0;
            ta_done     <= 1'b0;
            ma_done     <= 1'b0;
            gnt_q       <= bus.gnt;
        end else if (txn) begin
            if (eot || (!bus.frame && !bus.irdy))
                txn <= 1'b0;
            if (bus.irdy && bus.trdy)
                data_seen <= 1'b1;
            if (bus.devsel)
                devsel_seen <= 1'b1;
            if (!irdy_seen && bus.irdy) begin
                irdy_seen <= 1'b1;
                burst_q   <= bus.frame;
            end
            if (ta_now)
                ta_done <= 1'b1;
            if (ma_now)
                ma_done <= 1'b1;
        end
    end

    // A closed transaction never reopens without an address phase.
    a_r8_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn && !bus.frame) |=> !txn);

endmodule

// File: rtl/pci_cyc_mabort.sv
// Master-abort timer: counts clocks since the address phase and fires once
// when the limit for the transfer type is reached with no DEVSEL#.
// Assumes: MA_BURST >= MA_SINGLE >= 1; counter saturates, so it fires once.
module pci_cyc_mabort #(
    parameter int MA_SINGLE = 5,
    parameter int MA_BURST  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic txn,
    input  logic devsel_a,
    input  logic devsel_seen,
    input  logic burst_now,
    output logic ma_now
);

    localparam int CNT_W = $clog2(MA_BURST + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_S   = CNT_W'(MA_SINGLE);
    localparam logic [CNT_W-1:0] LIM_B   = CNT_W'(MA_BURST);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Clock counter: holds k in the k-th clock after the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(1);
        else if (txn && cnt != CNT_MAX)
            cnt <= cnt + CNT_W'(1);
    end

    // Limit selection and timeout compare.
    always_comb begin
        limit  = burst_now ? LIM_B : LIM_S;
        ma_now = txn && !devsel_seen && !devsel_a && (cnt == limit);
    end

    a_r6_ma_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ma_now |=> !ma_now);

    a_r7_ma_not_before_single: assert property (@(posedge clk) disable iff (!rst_n)
        ma_now |-> (cnt >= LIM_S));

endmodule

// File: rtl/pci_cyc_decode.sv
// Cycle decoder: turns the current bus lines and the transaction history
// into the per-clock status set.
// Assumes: history inputs come from registers, so no combinational loop.
module pci_cyc_decode
    import pci_cyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  bus_t  bus,
    input  logic  txn,
    input  logic  data_seen,
    input  logic  devsel_seen,
    input  logic  ta_done,
    input  logic  ma_now,
    input  logic  ma_done,
    output stat_t st
);

    // Status decode for the current clock.
    always_comb begin
        st.idle   = !bus.frame && !bus.irdy;
        st.dvalid = txn && bus.irdy && bus.trdy;
        st.mwait  = txn && bus.frame && !bus.irdy;
        st.twait  = txn && bus.irdy && bus.devsel && !bus.trdy && !bus.stop;
        st.nodev  = txn && bus.irdy && !bus.trdy && !bus.devsel && !devsel_seen;
        st.retry  = txn && bus.stop && bus.devsel && !bus.trdy && !data_seen;
        st.tabort = txn && bus.stop && !bus.devsel && devsel_seen && !ta_done;
        st.mabort = ma_now;
        st.eot    = txn && !bus.frame && bus.irdy &&
                    (bus.trdy || bus.stop || ma_now || ma_done);
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st.idle |-> !(st.dvalid || st.mwait || st.twait || st.nodev || st.eot));

    a_r5_ta_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        st.tabort |=> !st.tabort);

    a_r8_eot_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        st.eot |=> !st.eot);

endmodule

// File: rtl/pci_cyc_qualify.sv
// Output stage: store qualification from the filters and the held grant.
// Assumes: filter inputs are static over the clocks they apply to.
module pci_cyc_qualify
    import pci_cyc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t st,
    input  logic  no_wait,
    input  logic  no_idle,
    input  logic  txn,
    input  logic  gnt_a,
    input  logic  gnt_q,
    output logic  store,
    output logic  gnt_held
);

    logic any_wait;

    // Filter decision and grant selection.
    always_comb begin
        any_wait = st.mwait || st.twait || st.nodev;
        store    = !(no_wait && any_wait) && !(no_idle && st.idle);
        gnt_held = txn ? gnt_q : gnt_a;
    end

    a_r10_wait_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (no_wait && (st.mwait || st.twait || st.nodev)) |-> !store);

    a_r11_idle_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (no_idle && st.idle) |-> !store);

endmodule

// File: rtl/pci_cycle_classifier.sv
// Top level: passive PCI cycle classifier. Converts the sampled active-low
// bus lines, runs the tracker, timer, decoder and output stage, and drives
// active-low status bits.
// Assumes: inputs are already registered on the bus clock.
module pci_cycle_classifier #(
    parameter int MA_SINGLE = 5,
    parameter int MA_BURST  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic devsel_n,
    input  logic stop_n,
    input  logic gnt_n,
    input  logic no_wait,
    input  logic no_idle,
    output logic idle_n,
    output logic dvalid_n,
    output logic mwait_n,
    output logic twait_n,
    output logic nodev_n,
    output logic retry_n,
    output logic tabort_n,
    output logic mabort_n,
    output logic eot_n,
    output logic gnt_held_n,
    output logic store_q
);
    import pci_cyc_pkg::*;

    bus_t  bus;
    stat_t st;
    logic  txn, start, data_seen, devsel_seen, irdy_seen, burst_q;
    logic  ta_done, ma_done, gnt_q, ma_now, burst_now, gnt_held;

    // Polarity conversion of the sampled lines.
    always_comb begin
        bus.frame  = !frame_n;
        bus.irdy   = !irdy_n;
        bus.trdy   = !trdy_n;
        bus.devsel = !devsel_n;
        bus.stop   = !stop_n;
        bus.gnt    = !gnt_n;
    end

    // Burst decision: latched on the first IRDY#, or taken live on that clock.
    assign burst_now = irdy_seen ? burst_q : (txn && bus.irdy && bus.frame);

    pci_cyc_track u_track (
        .clk(clk), .rst_n(rst_n), .bus(bus), .eot(st.eot),
        .ta_now(st.tabort), .ma_now(ma_now), .txn(txn), .start(start),
        .data_seen(data_seen), .devsel_seen(devsel_seen), .irdy_seen(irdy_seen),
        .burst_q(burst_q), .ta_done(ta_done), .ma_done(ma_done), .gnt_q(gnt_q)
    );

    pci_cyc_mabort #(.MA_SINGLE(MA_SINGLE), .MA_BURST(MA_BURST)) u_mabort (
        .clk(clk), .rst_n(rst_n), .start(start), .txn(txn),
        .devsel_a(bus.devsel), .devsel_seen(devsel_seen),
        .burst_now(burst_now), .ma_now(ma_now)
    );

    pci_cyc_decode u_decode (
        .clk(clk), .rst_n(rst_n), .bus(bus), .txn(txn), .data_seen(data_seen),
        .devsel_seen(devsel_seen), .ta_done(ta_done), .ma_now(ma_now),
        .ma_done(ma_done), .st(st)
    );

    pci_cyc_qualify u_qualify (
        .clk(clk), .rst_n(rst_n), .st(st), .no_wait(no_wait), .no_idle(no_idle),
        .txn(txn), .gnt_a(bus.gnt), .gnt_q(gnt_q), .store(store_q),
        .gnt_held(gnt_held)
    );

    // Active-low output drive.
    always_comb begin
        idle_n     = !st.idle;
        dvalid_n   = !st.dvalid;
        mwait_n    = !st.mwait;
        twait_n    = !st.twait;
        nodev_n    = !st.nodev;
        retry_n    = !st.retry;
        tabort_n   = !st.tabort;
        mabort_n   = !st.mabort;
        eot_n      = !st.eot;
        gnt_held_n = !gnt_held;
    end

    a_r6_ma_without_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        !mabort_n |-> devsel_n);

    a_r9_grant_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (txn && $past(txn)) |-> $stable(gnt_held_n));

endmodule

// File: tb/pci_cycle_classifier_test.sv
// Scoreboard bench: the driver task applies one clock of bus lines and pushes
// the expected status vector; the monitor pops and compares a quarter period
// after the driving edge.
module pci_cycle_classifier_test;

    localparam int CLK_PERIOD = 10;

    // Expected-vector bit positions (asserted = 1).
    localparam logic [10:0] IDL = 11'd1 << 0;
    localparam logic [10:0] DV  = 11'd1 << 1;
    localparam logic [10:0] MW  = 11'd1 << 2;
    localparam logic [10:0] TW  = 11'd1 << 3;
    localparam logic [10:0] NW  = 11'd1 << 4;
    localparam logic [10:0] RT  = 11'd1 << 5;
    localparam logic [10:0] TA  = 11'd1 << 6;
    localparam logic [10:0] MA  = 11'd1 << 7;
    localparam logic [10:0] EO  = 11'd1 << 8;
    localparam logic [10:0] GH  = 11'd1 << 9;
    localparam logic [10:0] SQ  = 11'd1 << 10;
    localparam logic [10:0] NONE = 11'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic devsel_n = 1'b1, stop_n = 1'b1, gnt_n = 1'b1;
    logic no_wait = 1'b0, no_idle = 1'b0;
    logic idle_n, dvalid_n, mwait_n, twait_n, nodev_n, retry_n;
    logic tabort_n, mabort_n, eot_n, gnt_held_n, store_q;

    logic cfg_rst = 1'b0, cfg_nw = 1'b0, cfg_ni = 1'b0;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = !clk;

    pci_cycle_classifier uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .gnt_n(gnt_n),
        .no_wait(no_wait), .no_idle(no_idle), .idle_n(idle_n),
        .dvalid_n(dvalid_n), .mwait_n(mwait_n), .twait_n(twait_n),
        .nodev_n(nodev_n), .retry_n(retry_n), .tabort_n(tabort_n),
        .mabort_n(mabort_n), .eot_n(eot_n), .gnt_held_n(gnt_held_n),
        .store_q(store_q)
    );

    // Driver: one clock of stimulus (1 = asserted) plus its expected status.
    task automatic step(input logic f, input logic i, input logic t,
                        input logic d, input logic s, input logic g,
                        input logic [10:0] exp, input string tag);
        logic sq;
        @(negedge clk);
        rst_n    = cfg_rst;
        no_wait  = cfg_nw;
        no_idle  = cfg_ni;
        frame_n  = !f;
        irdy_n   = !i;
        trdy_n   = !t;
        devsel_n = !d;
        stop_n   = !s;
        gnt_n    = !g;
        sq = !(cfg_nw && ((exp & (MW | TW | NW)) != 0)) &&
             !(cfg_ni && ((exp & IDL) != 0));
        exp_q.push_back(exp | (sq ? SQ : NONE));
        tag_q.push_back(tag);
    endtask

    task automatic idle_clocks(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0,0,0,0,0,0, IDL, tag);
    endtask

    // Monitor: compare the outputs a quarter period after the driving edge.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() != 0) begin
            logic [10:0] act;
            logic [10:0] exp;
            string tag;
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            act = {store_q, !gnt_held_n, !eot_n, !mabort_n, !tabort_n,
                   !retry_n, !nodev_n, !twait_n, !mwait_n, !dvalid_n, !idle_n};
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s: status actual=%b expected=%b", tag, act, exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R12: reset state with an idle bus.
        cfg_rst = 1'b0;
        idle_clocks(2, "R12 reset");
        cfg_rst = 1'b1;
        idle_clocks(1, "R12 after reset");

        // R2 R3 R8 R9: single read, target wait then data, grant held.
        step(1,0,0,0,0,1, GH,             "R9 single addr grant");
        step(0,1,0,1,0,0, TW | GH,        "R3 target wait, R9 hold");
        step(0,1,1,1,0,0, DV | EO | GH,   "R2 data, R8 eot");
        idle_clocks(1, "R1 idle after single");

        // R2 R3 R8: burst with master wait, target wait, two data beats.
        step(1,0,0,0,0,1, GH,             "R9 burst addr");
        step(1,0,0,1,0,0, MW | GH,        "R3 master wait");
        step(1,1,0,1,0,0, TW | GH,        "R3 target wait burst");
        step(1,1,1,1,0,0, DV | GH,        "R2 burst beat 1");
        step(0,1,1,1,0,0, DV | EO | GH,   "R8 burst last beat");
        idle_clocks(1, "R1 idle after burst");

        // R4 R9: retry, grant not asserted at address phase.
        step(1,0,0,0,0,0, NONE,           "R9 retry addr no grant");
        step(1,1,0,1,1,1, RT,             "R4 retry, R9 late grant ignored");
        step(0,1,0,1,1,1, RT | EO,        "R4 retry end, R8");
        step(0,0,0,0,0,1, IDL | GH,       "R9 grant passes when idle");

        // R5: target abort after a data beat, one clock only.
        step(1,0,0,0,0,0, NONE,           "R5 addr");
        step(1,1,1,1,0,0, DV,             "R5 data before abort");
        step(1,1,0,0,1,0, TA,             "R5 target abort");
        step(0,1,0,0,1,0, EO,             "R5 abort one clock, R8");
        idle_clocks(1, "R1 idle after abort");

        // R6 R11: single-transfer master abort, idle filter on.
        cfg_ni = 1'b1;
        step(0,0,0,0,0,0, IDL,            "R11 idle dropped");
        step(1,0,0,0,0,0, NONE,           "R6 addr");
        step(0,1,0,0,0,0, NW,             "R3 no-devsel wait 1");
        step(0,1,0,0,0,0, NW,             "R6 clock 2");
        step(0,1,0,0,0,0, NW,             "R6 clock 3");
        step(0,1,0,0,0,0, NW,             "R6 clock 4");
        step(0,1,0,0,0,0, NW | MA | EO,   "R6 abort at clock 5");
        step(0,0,0,0,0,0, IDL,            "R11 idle dropped after");
        cfg_ni = 1'b0;

        // R7 R10: burst master abort, wait filter on.
        cfg_nw = 1'b1;
        step(1,0,0,0,0,0, NONE,           "R7 addr");
        step(1,1,0,0,0,0, NW,             "R10 wait dropped 1");
        step(1,1,0,0,0,0, NW,             "R10 wait dropped 2");
        step(1,1,0,0,0,0, NW,             "R7 clock 3");
        step(1,1,0,0,0,0, NW,             "R7 clock 4");
        step(1,1,0,0,0,0, NW,             "R7 no abort at clock 5");
        step(1,1,0,0,0,0, NW | MA,        "R7 abort at clock 6");
        step(0,1,0,0,0,0, NW | EO,        "R7 end after abort, R8");
        step(0,0,0,0,0,0, IDL,            "R10 idle still stored");
        cfg_nw = 1'b0;

        // R10 R11: master wait stored when only the idle filter is on.
        cfg_ni = 1'b1;
        step(1,0,0,0,0,0, NONE,           "R11 addr stored");
        step(1,0,0,1,0,0, MW,             "R10 wait kept, filter off");
        step(0,1,1,1,0,0, DV | EO,        "R2 data, R8 eot");
        step(0,0,0,0,0,0, IDL,            "R11 idle dropped");
        cfg_ni = 1'b0;
        idle_clocks(2, "R11 filters off");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule